// File: doc/BRIEF.md
# Write-once protected configuration register

This block is a single 8-bit system configuration register on a simple bus. The bus has an address, a write strobe, write data and combinational read data. Three of its bits can be changed by software at any time. The other five are guarded: after reset they take one write, and only while a post-reset window of 64 clock cycles is still open. Once that write has landed, or the window has run out, whichever comes first, the guarded bits keep their value and ignore further writes.

A special-mode input removes the guard. While it is high, every bit takes every write, whether or not the window is open. Each bit also drives a named field output, so the rest of the chip sees the configuration directly.

The register answers at one fixed address. Writes to any other address are ignored and do not use up the single allowed write.

Top module: `cfg_guard_reg`

## Requirements
- R1: After reset the register reads 0x10, and the field outputs carry the same pattern.
- R2: The register answers only at address 0x39. A read at any other address returns 0x00. A write at any other address changes nothing and does not count as the single write.
- R3: The window counts clock edges after reset is released. The first edge is cycle 0. A guarded write on the edge of cycle 63 is accepted, and one on the edge of cycle 64 or later is ignored. The count saturates at 64.
- R4: In normal mode, the first write to 0x39 locks the guarded bits. A later write inside the window leaves them unchanged, and the lock does not clear until reset.
- R5: While special_mode is high, every write to 0x39 loads all eight bits, in or out of the window and however many earlier writes there were. Writes made in special mode do not set the single-write lock.
- R6: Bits 7, 6 and 3 (mask 0xC8) take every write to 0x39 in every mode. Bits 5, 4, 2, 1 and 0 (mask 0x37) are the guarded bits.
- R7: One write updates all free bits and, when the guard is not applied, all guarded bits on the same clock edge. The new value reads back in the following cycle.
- R8: The field outputs follow the bit order, from bit 7 down to bit 0: A/D power enable, clock source select, IRQ edge mode, oscillator start delay, clock monitor enable, clock monitor force, and watchdog rate[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | High: guarded bits always writable |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| adc_pwr_en | output | 1 | Bit 7 field |
| clk_sel_rc | output | 1 | Bit 6 field |
| irq_edge | output | 1 | Bit 5 field |
| osc_delay | output | 1 | Bit 4 field |
| clkmon_en | output | 1 | Bit 3 field |
| clkmon_force | output | 1 | Bit 2 field |
| wdog_rate | output | 2 | Bits 1:0 field |

## Verification
Read data depends only on the address and the stored value, so a read is valid in the same cycle its address is presented. A write takes effect on the clock edge where the strobe is seen, and the new value appears at the read port and the field outputs right after that edge. The driver raises the strobe at a falling edge and drops it at the next falling edge. It then queues the expected value, and the monitor samples one time unit after that falling edge, so every comparison falls one whole edge after the write. The bench counts rising edges since reset release, which places a write on the exact edge of cycle 63 or cycle 64.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 8;
  localparam logic [ADDR_W-1:0] REG_ADDR = 8'h39;
  localparam logic [REG_W-1:0]  RESET_VAL = 8'h10;

  localparam int B_ADPWR  = 7;
  localparam int B_CKSEL  = 6;
  localparam int B_IRQEDG = 5;
  localparam int B_OSCDLY = 4;
  localparam int B_CMEN   = 3;
  localparam int B_CMFRC  = 2;
  localparam int B_RATE1  = 1;
  localparam int B_RATE0  = 0;

  localparam logic [REG_W-1:0] PROT_MASK =
    REG_W'((1 << B_IRQEDG) | (1 << B_OSCDLY) | (1 << B_CMFRC) | (1 << B_RATE1) | (1 << B_RATE0));
  localparam logic [REG_W-1:0] FREE_MASK = ~PROT_MASK;

  // Merge a bus write into the stored value; guarded bits keep old value when held.
  function automatic logic [REG_W-1:0] merge_write(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] new_v,
    input logic             hold);
    logic [REG_W-1:0] prot_src;
    prot_src = hold ? old_v : new_v;
    return (new_v & FREE_MASK) | (prot_src & PROT_MASK);
  endfunction
endpackage

// File: rtl/cfg_window_timer.sv
module cfg_window_timer #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic window_done
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign window_done = (cnt == LIMIT);

  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |=> window_done);
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !window_done |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store
  import cfg_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             special_mode,
  input  logic [REG_W-1:0] wdata,
  input  logic             window_done,
  output logic [REG_W-1:0] q,
  output logic             locked
);
  logic written_q;
  logic guard_on;

  assign locked   = window_done | written_q;
  assign guard_on = locked & ~special_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q         <= RESET_VAL;
      written_q <= 1'b0;
    end else if (wr_hit) begin
      q <= merge_write(q, wdata, guard_on);
      if (!special_mode) written_q <= 1'b1;
    end
  end

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  p_prot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && locked && !special_mode) |=> $stable(q & PROT_MASK));
  p_free_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q & FREE_MASK) == ($past(wdata) & FREE_MASK)));
  p_special_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && special_mode) |=> (q == $past(wdata)));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));
endmodule

// File: rtl/cfg_guard_reg.sv
module cfg_guard_reg
  import cfg_guard_pkg::*;
#(
  parameter int WINDOW = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        special_mode,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        adc_pwr_en,
  output logic        clk_sel_rc,
  output logic        irq_edge,
  output logic        osc_delay,
  output logic        clkmon_en,
  output logic        clkmon_force,
  output logic [1:0]  wdog_rate
);
  logic             addr_hit;
  logic             wr_hit;
  logic             window_done;
  logic             locked;
  logic [REG_W-1:0] q;

  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_wr & addr_hit;

  cfg_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .window_done(window_done));

  cfg_bit_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .special_mode(special_mode),
    .wdata(bus_wdata), .window_done(window_done), .q(q), .locked(locked));

  assign bus_rdata    = addr_hit ? q : '0;
  assign adc_pwr_en   = q[B_ADPWR];
  assign clk_sel_rc   = q[B_CKSEL];
  assign irq_edge     = q[B_IRQEDG];
  assign osc_delay    = q[B_OSCDLY];
  assign clkmon_en    = q[B_CMEN];
  assign clkmon_force = q[B_CMFRC];
  assign wdog_rate    = q[B_RATE1:B_RATE0];

  p_miss_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !addr_hit) |=> $stable(q));
  p_window_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    window_done |-> locked);
endmodule

// File: tb/sim_cfg_guard_reg.sv
module sim_cfg_guard_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic [7:0] bus_addr = 8'h39;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic adc_pwr_en, clk_sel_rc, irq_edge, osc_delay, clkmon_en, clkmon_force;
  logic [1:0] wdog_rate;

  always #4 clk = ~clk;

  cfg_guard_reg u0 (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_pwr_en(adc_pwr_en), .clk_sel_rc(clk_sel_rc), .irq_edge(irq_edge),
    .osc_delay(osc_delay), .clkmon_en(clkmon_en), .clkmon_force(clkmon_force),
    .wdog_rate(wdog_rate));

  typedef struct {
    logic [7:0] exp;
    bit         fields;
    string      req;
  } item_t;

  item_t sb[$];
  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Expected value for the guarded byte: free bits always from data.
  function automatic logic [7:0] model(input logic [7:0] old_v, input logic [7:0] d,
                                       input bit accept_prot);
    logic [7:0] r;
    r = {d[7], d[6], old_v[5], old_v[4], d[3], old_v[2], old_v[1:0]};
    if (accept_prot) r = d;
    return r;
  endfunction

  // Monitor: pops one item per falling edge and compares shortly after.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = it.fields ? {adc_pwr_en, clk_sel_rc, irq_edge, osc_delay, clkmon_en,
                           clkmon_force, wdog_rate} : bus_rdata;
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_at(input int k, input logic [7:0] a, input logic [7:0] d);
    while (cyc < k) @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string req);
    item_t it;
    bus_addr = a;
    it.exp = e; it.fields = 1'b0; it.req = req;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic expect_fields(input logic [7:0] e, input string req);
    item_t it;
    it.exp = e; it.fields = 1'b1; it.req = req;
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    // R1 reset value
    do_reset();
    expect_rd(8'h39, 8'h10, "R1 reset read");
    expect_fields(8'h10, "R1 reset fields");

    // R3 write on cycle 63 accepted; R4 later write keeps guarded bits
    do_reset();
    write_at(63, 8'h39, 8'hFF);
    expect_rd(8'h39, model(8'h10, 8'hFF, 1'b1), "R3 cycle63 accepted");
    expect_fields(8'hFF, "R8 field order");
    write_at(70, 8'h39, 8'h00);
    expect_rd(8'h39, model(8'hFF, 8'h00, 1'b0), "R6 free bits after lock");

    // R3 write on cycle 64 ignored for guarded bits
    do_reset();
    write_at(64, 8'h39, 8'hFF);
    expect_rd(8'h39, model(8'h10, 8'hFF, 1'b0), "R3 cycle64 ignored");

    // R4 second write in window ignored; R7 both classes update on one edge
    do_reset();
    write_at(5, 8'h39, 8'h27);
    expect_rd(8'h39, 8'h27, "R7 first write all bits");
    write_at(10, 8'h39, 8'hD8);
    expect_rd(8'h39, model(8'h27, 8'hD8, 1'b0), "R4 second write in window");
    write_at(80, 8'h39, 8'h08);
    expect_rd(8'h39, model(8'h27, 8'h08, 1'b0), "R4 lock persists");

    // R5 special mode writes always accepted
    do_reset();
    special_mode = 1'b1;
    write_at(3, 8'h39, 8'hFF);
    expect_rd(8'h39, 8'hFF, "R5 special in window");
    write_at(6, 8'h39, 8'h00);
    expect_rd(8'h39, 8'h00, "R5 special repeat");
    write_at(100, 8'h39, 8'hA5);
    expect_rd(8'h39, 8'hA5, "R5 special after window");
    special_mode = 1'b0;
    write_at(110, 8'h39, 8'h00);
    expect_rd(8'h39, model(8'hA5, 8'h00, 1'b0), "R5 normal after special");

    // R5 special writes do not use the single write
    do_reset();
    special_mode = 1'b1;
    write_at(2, 8'h39, 8'h33);
    special_mode = 1'b0;
    write_at(8, 8'h39, 8'h04);
    expect_rd(8'h39, 8'h04, "R5 special leaves once unused");

    // R2 other address
    do_reset();
    write_at(2, 8'h38, 8'hFF);
    expect_rd(8'h39, 8'h10, "R2 miss write ignored");
    expect_rd(8'h38, 8'h00, "R2 miss read zero");
    write_at(12, 8'h39, 8'h00);
    expect_rd(8'h39, 8'h00, "R2 miss did not lock");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule